// File: doc/BRIEF.md
# Margin-Selecting Slew-Limited Reference Ramp

This block produces the signed offset that is applied to an output-voltage reference. One count is 0.1% of the reference. Three signed registers hold candidate offsets: a nominal setting, a raised margin setting and a lowered margin setting. The block chooses one of them as the target. A three-state margin pin decides the choice first. Only when the pin is floating does a two-bit operation field decide it.

The block does not jump to a new target. The output register moves by exactly one count toward the target on each cycle where the step tick is high, and it holds on all other cycles. A bypass input removes the slew limit, and the output then loads the target in a single cycle.

Each register value is clamped to the usable window of ±250 counts before it can become a target. A settled flag shows when the output has reached the target.

Top module: `mrgn_ref_ramp`

## Requirements
- R1: While rst_ni is low, and after it is released, `ofs_o` reads 0 until the first update.
- R2: With `pin_i` = 2'b00 (pin low), the target is the clamped `mlo_i`, whatever the value of `op_i`.
- R3: With `pin_i` = 2'b01 (pin high), the target is the clamped `mhi_i`, whatever the value of `op_i`.
- R4: With `pin_i` = 2'b10 or 2'b11 (floating), `op_i` selects the target: 2'b00 selects `cmd_i`, 2'b01 selects `mlo_i`, and 2'b10 selects `mhi_i`.
- R5: With the pin floating, `op_i` = 2'b11 is illegal and selects `cmd_i`.
- R6: Before use as a target, a register value above +250 becomes +250 and a value below -250 becomes -250.
- R7: With `bypass_i` low, a clock edge with `step_i` high moves `ofs_o` by one count toward the target. A clock edge with `step_i` low leaves `ofs_o` unchanged.
- R8: With `bypass_i` high, `ofs_o` takes the target value on the next clock edge.
- R9: If the target changes during a ramp, stepping continues from the present `ofs_o` toward the new target.
- R10: `settled_o` is high exactly when `ofs_o` equals the current target. While it is high, `ofs_o` does not move.
- R11: `ofs_o` always stays within ±250.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 9 | Nominal offset, two's complement, 0.1% per count |
| mhi_i | input | 9 | Raised margin offset, two's complement |
| mlo_i | input | 9 | Lowered margin offset, two's complement |
| pin_i | input | 2 | Margin pin state: 00 low, 01 high, 1x floating |
| op_i | input | 2 | Operation margin field: bit 1 selects high, bit 0 selects low |
| step_i | input | 1 | Step-enable tick |
| bypass_i | input | 1 | High disables slew limiting |
| ofs_o | output | 9 | Active reference offset, two's complement |
| settled_o | output | 1 | Output equals target |

## Verification
The assertions assume that the register inputs, the pin state and the operation field hold steady around each clock edge. They also assume that any value on these inputs is legal. The pin-selection properties only apply when the selected register is already inside ±250, so the clamp is exercised by bench checks rather than by those properties. The stimulus changes inputs only just after the falling edge. It covers every pin and operation code, including the illegal code 11 and the pin value 11. It drives register values at and beyond both clamp limits and mixes sparse step ticks with retargeting in the middle of a ramp.

// File: rtl/mrgn_pkg.sv
package mrgn_pkg;
  localparam logic [1:0] PIN_LOW  = 2'b00;
  localparam logic [1:0] PIN_HIGH = 2'b01;

  typedef enum logic [1:0] {
    SRC_CMD = 2'd0,
    SRC_LO  = 2'd1,
    SRC_HI  = 2'd2
  } src_e;

  localparam int NUM_SRC = 3;
endpackage

// File: rtl/mrgn_clamp.sv
module mrgn_clamp #(
  parameter int W   = 9,
  parameter int LIM = 250
) (
  input  logic signed [W-1:0] raw_i,
  output logic signed [W-1:0] lim_o
);
  localparam logic signed [W-1:0] HI = $signed(W'(LIM));
  localparam logic signed [W-1:0] LO = -HI;

  always_comb begin
    if (raw_i > HI)      lim_o = HI;
    else if (raw_i < LO) lim_o = LO;
    else                 lim_o = raw_i;
  end
endmodule

// File: rtl/mrgn_tgt_sel.sv
module mrgn_tgt_sel
  import mrgn_pkg::*;
#(
  parameter int W = 9
) (
  input  logic signed [W-1:0] val_i [NUM_SRC],
  input  logic [1:0]          pin_i,
  input  logic [1:0]          op_i,
  output logic signed [W-1:0] tgt_o
);
  src_e src;

  // pin overrides operation field; op 11 falls back to nominal
  always_comb begin
    if (pin_i == PIN_LOW)       src = SRC_LO;
    else if (pin_i == PIN_HIGH) src = SRC_HI;
    else begin
      unique case (op_i)
        2'b01:   src = SRC_LO;
        2'b10:   src = SRC_HI;
        default: src = SRC_CMD;
      endcase
    end
  end

  assign tgt_o = val_i[src];
endmodule

// File: rtl/mrgn_ramp.sv
module mrgn_ramp #(
  parameter int W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] tgt_i,
  input  logic                step_i,
  input  logic                bypass_i,
  output logic signed [W-1:0] q_o,
  output logic                at_tgt_o
);
  localparam logic signed [W-1:0] ONE = $signed(W'(1));

  logic signed [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               q <= '0;
    else if (bypass_i)         q <= tgt_i;
    else if (step_i) begin
      if (q < tgt_i)           q <= q + ONE;
      else if (q > tgt_i)      q <= q - ONE;
    end
  end

  assign q_o      = q;
  assign at_tgt_o = (q == tgt_i);
endmodule

// File: rtl/mrgn_ref_ramp.sv
module mrgn_ref_ramp
  import mrgn_pkg::*;
#(
  parameter int W   = 9,
  parameter int LIM = 250
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] cmd_i,
  input  logic signed [W-1:0] mhi_i,
  input  logic signed [W-1:0] mlo_i,
  input  logic [1:0]          pin_i,
  input  logic [1:0]          op_i,
  input  logic                step_i,
  input  logic                bypass_i,
  output logic signed [W-1:0] ofs_o,
  output logic                settled_o
);
  logic signed [W-1:0] raw [NUM_SRC];
  logic signed [W-1:0] lim [NUM_SRC];
  logic signed [W-1:0] tgt;

  assign raw[SRC_CMD] = cmd_i;
  assign raw[SRC_LO]  = mlo_i;
  assign raw[SRC_HI]  = mhi_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_clamp
    mrgn_clamp #(.W(W), .LIM(LIM)) i_clamp (
      .raw_i (raw[g]),
      .lim_o (lim[g])
    );
  end

  mrgn_tgt_sel #(.W(W)) i_sel (
    .val_i (lim),
    .pin_i (pin_i),
    .op_i  (op_i),
    .tgt_o (tgt)
  );

  mrgn_ramp #(.W(W)) i_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tgt_i    (tgt),
    .step_i   (step_i),
    .bypass_i (bypass_i),
    .q_o      (ofs_o),
    .at_tgt_o (settled_o)
  );
endmodule

// File: rtl/mrgn_ref_ramp_chk.sv
module mrgn_ref_ramp_chk
  import mrgn_pkg::*;
#(
  parameter int W   = 9,
  parameter int LIM = 250
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic signed [W-1:0] mhi_i,
  input logic signed [W-1:0] mlo_i,
  input logic [1:0]          pin_i,
  input logic                step_i,
  input logic                bypass_i,
  input logic signed [W-1:0] ofs_o,
  input logic                settled_o,
  input logic signed [W-1:0] tgt
);
  localparam logic signed [W-1:0] HI  = $signed(W'(LIM));
  localparam logic signed [W-1:0] LO  = -HI;
  localparam logic signed [W-1:0] ONE = $signed(W'(1));

  AST_PIN_LOW_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_i == PIN_LOW && mlo_i <= HI && mlo_i >= LO) |-> tgt == mlo_i); // R2
  AST_PIN_HIGH_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_i == PIN_HIGH && mhi_i <= HI && mhi_i >= LO) |-> tgt == mhi_i); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !bypass_i) |=> $stable(ofs_o)); // R7
  AST_ONE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass_i |=> (ofs_o == $past(ofs_o) || ofs_o == $past(ofs_o) + ONE
                   || ofs_o == $past(ofs_o) - ONE)); // R7
  AST_BYPASS_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> ofs_o == $past(tgt)); // R8
  AST_SETTLED_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled_o && !bypass_i) |=> $stable(ofs_o)); // R10
  AST_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs_o <= HI && ofs_o >= LO)); // R11
endmodule

bind mrgn_ref_ramp mrgn_ref_ramp_chk #(.W(W), .LIM(LIM)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mhi_i     (mhi_i),
  .mlo_i     (mlo_i),
  .pin_i     (pin_i),
  .step_i    (step_i),
  .bypass_i  (bypass_i),
  .ofs_o     (ofs_o),
  .settled_o (settled_o),
  .tgt       (tgt)
);

// File: tb/test_mrgn_ref_ramp.sv
module test_mrgn_ref_ramp;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic signed [8:0] cmd_i = '0, mhi_i = '0, mlo_i = '0;
  logic [1:0]        pin_i = 2'b10, op_i = 2'b00;
  logic              step_i = 1'b0, bypass_i = 1'b0;
  logic signed [8:0] ofs_o;
  logic              settled_o;

  int checks = 0;
  int errors = 0;
  int m_out  = 0;

  always #5 clk_i = ~clk_i;

  mrgn_ref_ramp i_mrgn_ref_ramp (.*);

  function automatic int clampi(int v);
    if (v > 250)  return 250;
    if (v < -250) return -250;
    return v;
  endfunction

  function automatic int m_tgt();
    int c, h, l;
    c = clampi(int'(cmd_i)); h = clampi(int'(mhi_i)); l = clampi(int'(mlo_i));
    if (pin_i == 2'b00) return l;
    if (pin_i == 2'b01) return h;
    if (op_i == 2'b01)  return l;
    if (op_i == 2'b10)  return h;
    return c;
  endfunction

  task automatic check(string tag);
    int t;
    t = m_tgt();
    checks++;
    if (int'(ofs_o) != m_out) begin
      errors++;
      $display("FAIL %s ofs actual %0d expected %0d", tag, ofs_o, m_out);
    end
    checks++;
    if (settled_o != (m_out == t)) begin
      errors++;
      $display("FAIL %s settled actual %0b expected %0b", tag, settled_o, m_out == t);
    end
  endtask

  // one clock: model updates at posedge, compare at negedge
  task automatic cyc(string tag);
    int t;
    @(posedge clk_i);
    t = m_tgt();
    if (bypass_i)    m_out = t;
    else if (step_i) m_out = (m_out < t) ? m_out + 1 : (m_out > t) ? m_out - 1 : m_out;
    @(negedge clk_i);
    check(tag);
  endtask

  task automatic jump(string tag);
    bypass_i = 1'b1; cyc(tag); bypass_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    check("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1");
    cmd_i = 9'sd40; mhi_i = 9'sd120; mlo_i = -9'sd75;
    cyc("R1");

    // R2 pin low overrides every op code
    pin_i = 2'b00;
    for (int o = 0; o < 4; o++) begin op_i = 2'(o); jump("R2"); end
    // R3 pin high overrides every op code
    pin_i = 2'b01;
    for (int o = 0; o < 4; o++) begin op_i = 2'(o); jump("R3"); end
    // R4 floating, both floating codes
    for (int p = 2; p < 4; p++) begin
      pin_i = 2'(p);
      op_i = 2'b00; jump("R4");
      op_i = 2'b01; jump("R4");
      op_i = 2'b10; jump("R4");
      op_i = 2'b11; jump("R5");
    end
    // R6 clamping at both ends
    pin_i = 2'b10; op_i = 2'b00;
    cmd_i = 9'sd255;  jump("R6");
    cmd_i = 9'sd251;  jump("R6");
    cmd_i = -9'sd256; jump("R6");
    cmd_i = -9'sd251; jump("R6");
    cmd_i = 9'sd250;  jump("R6");

    // R7 full-scale ramp with sparse ticks, R11 range
    cmd_i = -9'sd250;
    for (int i = 0; i < 1100; i++) begin
      step_i = (i % 2 == 0);
      cyc("R7");
    end
    step_i = 1'b0;
    cmd_i = 9'sd10; repeat (5) cyc("R7");
    step_i = 1'b1; repeat (300) cyc("R11");

    // R9 retarget mid ramp via pin then op field
    mhi_i = 9'sd60; mlo_i = -9'sd30;
    pin_i = 2'b01; repeat (20) cyc("R9");
    pin_i = 2'b00; repeat (30) cyc("R9");
    pin_i = 2'b11; op_i = 2'b10; repeat (60) cyc("R9");
    op_i = 2'b11; repeat (80) cyc("R9");

    // R10 settled holds with ticks running
    repeat (10) cyc("R10");
    // R8 bypass jump mid ramp
    cmd_i = -9'sd200; repeat (5) cyc("R8");
    jump("R8");
    cmd_i = 9'sd3; step_i = 1'b0; cyc("R10");
    step_i = 1'b1; repeat (10) cyc("R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule